// File: doc/BRIEF.md
# Phrase-to-pixel line buffer writer

The block turns a stream of 64-bit phrases of packed image data into pixels and stores them in a pair of line buffers. One buffer is filled while the other is read out for display, and a one-cycle swap pulse exchanges their roles. A swap may arrive at the start of a display line or in the middle of one. Before each object the caller latches its settings with a start pulse: pixel depth, a scaled flag, an additive (read-modify-write) flag and the starting x position. It then streams phrases over a valid/ready handshake. Pixels of 1 to 8 bits go through a 256-entry palette of 16-bit colours. 16-bit pixels are direct colours. 24-bit pixels arrive as two 32-bit containers per phrase.

Each buffer has DEPTH entries of 32 bits. The low half of an entry holds the even pixel and the high half holds the odd pixel, so a buffer spans 2*DEPTH pixels at 16 bits or less. A 24-bit pixel takes a whole entry, addressed by x directly. Unscaled objects of 16 bits or less write two neighbouring pixels in one cycle, one into each half. Scaled and 24-bit objects write one pixel per cycle. In additive mode a write happens only every other cycle.

Top module: `lbw_line_writer`

## Requirements
- R1: After reset, in_ready is 1, wr_even and wr_odd are 0, rd_data is 0 and buffer 0 is the one being filled.
- R2: Depth codes are 0=1, 1=2, 2=4, 3=8, 4=16 and 5=24 bits per pixel. Pixels leave a phrase starting at bit 63. Pixel k of an object lands at x = start_x + k. In 24-bit mode each pixel is the low 24 bits of a 32-bit container, two per phrase.
- R3: At depths of 8 bits or less, the stored colour is the palette entry at the pixel value. Palette entry i is loaded by pal_we with pal_idx=i and pal_color.
- R4: A pixel value of zero at depth codes 0 to 4 leaves the buffer entry untouched. A zero 24-bit pixel is written.
- R5: An unscaled object at 16 bits or less writes two pixels per write cycle, so N fully visible 16-bit phrases give 2N consecutive write cycles. A scaled or 24-bit object writes one pixel per write cycle.
- R6: With the additive flag set, the stored value becomes the old value plus the colour: modulo 2^16 per 16-bit half, and modulo 2^24 across an entry in 24-bit mode. Two write cycles are never adjacent.
- R7: A pixel with x at or above 2*DEPTH (depths up to 16) or at or above DEPTH (24-bit) is not written.
- R8: in_ready is 0 in the cycle after a phrase is accepted into the prefetch slot. The slot lets the next phrase be taken while the current one is being unpacked, so unscaled 16-bit data flows without gaps.
- R9: A swap pulse exchanges the fill buffer and the display buffer from the next clock edge. Reads captured at that same edge still see the old display buffer. Without a pulse the roles stay fixed.
- R10: rd_data returns {odd half, even half} of display entry rd_addr one cycle after rd_addr is presented. A 24-bit entry reads as {8'h00, colour}.
- R11: The object settings are sampled only on obj_start. Changing the settings inputs later has no effect on the object being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obj_start | input | 1 | Latches the object settings and start x |
| cfg_bpp | input | 3 | Depth code |
| cfg_scaled | input | 1 | Scaled object: one pixel per write |
| cfg_rmw | input | 1 | Additive write mode |
| cfg_start_x | input | XW | First pixel x position |
| in_valid | input | 1 | Phrase valid |
| in_data | input | 64 | Phrase data |
| in_ready | output | 1 | Phrase accepted when high with in_valid |
| pal_we | input | 1 | Palette write enable |
| pal_idx | input | 8 | Palette entry index |
| pal_color | input | 16 | Palette colour to store |
| swap | input | 1 | Exchange fill and display buffers |
| rd_addr | input | AW | Display entry address |
| rd_data | output | 32 | Display entry, registered |
| wr_even | output | 1 | Even half of an entry written this cycle |
| wr_odd | output | 1 | Odd half of an entry written this cycle |

## Verification
A wrong unpack count or a wrong shift shows up as pixels at wrong positions or wrong colours. These are visible in the readback after the next swap. A wrong prefetch flag or RMW phase shows up within one or two cycles on in_ready and the write strobes, as a broken write cadence. A wrong buffer select returns the other buffer's data on the very next read. Sweeping every depth at odd and even start positions up to the line end exposes errors in field extraction, in bank choice and in the range limit.

// File: rtl/lbw_pkg.sv
package lbw_pkg;

  typedef enum logic [2:0] {
    BPP1  = 3'd0,
    BPP2  = 3'd1,
    BPP4  = 3'd2,
    BPP8  = 3'd3,
    BPP16 = 3'd4,
    BPP24 = 3'd5
  } bpp_e;

  typedef struct packed {
    bpp_e bpp;
    logic scaled;
    logic rmw;
  } cfg_t;

  typedef struct packed {
    logic        en;
    logic [15:0] x;
    logic [23:0] col;
  } lane_t;

  // Unknown codes fall back to 16-bit direct colour.
  function automatic bpp_e decode_bpp(logic [2:0] code);
    case (code)
      3'd0:    return BPP1;
      3'd1:    return BPP2;
      3'd2:    return BPP4;
      3'd3:    return BPP8;
      3'd5:    return BPP24;
      default: return BPP16;
    endcase
  endfunction

  function automatic logic [2:0] log2_width(bpp_e b);
    return (b == BPP24) ? 3'd5 : 3'(b);
  endfunction

  // Field width in the phrase: 24-bit pixels use 32-bit containers.
  function automatic logic [5:0] field_w(bpp_e b);
    return 6'd1 << log2_width(b);
  endfunction

  function automatic logic is_pair(cfg_t c);
    return !c.scaled && (c.bpp != BPP24);
  endfunction

  function automatic logic [6:0] steps_per_phrase(cfg_t c);
    logic [6:0] pix;
    pix = 7'd64 >> log2_width(c.bpp);
    return is_pair(c) ? (pix >> 1) : pix;
  endfunction

  // Top-most field of a phrase, right aligned.
  function automatic logic [31:0] top_field(logic [63:0] ph, bpp_e b);
    logic [63:0] s;
    s = ph >> (7'd64 - {1'b0, field_w(b)});
    return s[31:0];
  endfunction

endpackage

// File: rtl/lbw_unpack.sv
module lbw_unpack
  import lbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        obj_start,
  input  logic [15:0] start_x,
  input  cfg_t        cfg,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  output logic        in_ready,
  output logic        fire,
  output logic        pair,
  output logic [31:0] px0,
  output logic [31:0] px1,
  output logic [15:0] x0
);

  logic [63:0] nxt_q, cur_q;
  logic        nxt_v, cur_v, phase;
  logic [6:0]  rem;
  logic [15:0] x_q;
  logic [5:0]  w;
  logic [6:0]  adv;
  logic        last, load;

  assign pair     = is_pair(cfg);
  assign w        = field_w(cfg.bpp);
  assign adv      = pair ? {w, 1'b0} : {1'b0, w};
  assign fire     = cur_v && (!cfg.rmw || phase);
  assign last     = fire && (rem == 7'd1);
  assign load     = nxt_v && (!cur_v || last);
  assign in_ready = !nxt_v;
  assign px0      = top_field(cur_q, cfg.bpp);
  assign px1      = top_field(cur_q << w, cfg.bpp);
  assign x0       = x_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_q <= '0;
      nxt_v <= 1'b0;
      cur_q <= '0;
      cur_v <= 1'b0;
      rem   <= '0;
      x_q   <= '0;
      phase <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        nxt_q <= in_data;
        nxt_v <= 1'b1;
      end else if (load) begin
        nxt_v <= 1'b0;
      end

      if (load) begin
        cur_q <= nxt_q;
        cur_v <= 1'b1;
        rem   <= steps_per_phrase(cfg);
      end else if (fire) begin
        cur_q <= cur_q << adv;
        rem   <= rem - 7'd1;
        if (last) cur_v <= 1'b0;
      end

      if (obj_start) begin
        x_q   <= start_x;
        phase <= 1'b0;
      end else begin
        if (fire) x_q <= x_q + (pair ? 16'd2 : 16'd1);
        if (cur_v && cfg.rmw) phase <= ~phase;
      end
    end
  end

endmodule

// File: rtl/lbw_pixmap.sv
module lbw_pixmap
  import lbw_pkg::*;
#(
  parameter int DEPTH = 360
) (
  input  logic        clk,
  input  logic        pal_we,
  input  logic [7:0]  pal_idx,
  input  logic [15:0] pal_color,
  input  cfg_t        cfg,
  input  logic        fire,
  input  logic        pair,
  input  logic [31:0] px0,
  input  logic [31:0] px1,
  input  logic [15:0] x0,
  output lane_t       lane0,
  output lane_t       lane1
);

  localparam int PAL_N = 256;
  localparam logic [15:0] LIM_NARROW = 16'(2 * DEPTH);
  localparam logic [15:0] LIM_WIDE   = 16'(DEPTH);

  logic [15:0] pal [PAL_N];
  lane_t       lanes [2];

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_idx] <= pal_color;
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [31:0] raw;
    logic [15:0] xp;
    logic        live, in_range, opaque;

    assign raw      = (i == 0) ? px0 : px1;
    assign xp       = x0 + 16'(i);
    assign live     = fire && ((i == 0) || pair);
    assign in_range = (cfg.bpp == BPP24) ? (xp < LIM_WIDE) : (xp < LIM_NARROW);
    assign opaque   = (cfg.bpp == BPP24) || (raw != 32'd0);

    always_comb begin
      lanes[i].en = live && in_range && opaque;
      lanes[i].x  = xp;
      if (cfg.bpp == BPP24)      lanes[i].col = raw[23:0];
      else if (cfg.bpp == BPP16) lanes[i].col = {8'h00, raw[15:0]};
      else                       lanes[i].col = {8'h00, pal[raw[7:0]]};
    end
  end

  assign lane0 = lanes[0];
  assign lane1 = lanes[1];

endmodule

// File: rtl/lbw_linebuf.sv
module lbw_linebuf
  import lbw_pkg::*;
#(
  parameter  int DEPTH = 360,
  localparam int AW    = $clog2(DEPTH),
  localparam int IW    = $clog2(2 * DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic          rmw,
  input  logic          wide,
  input  lane_t         lane0,
  input  lane_t         lane1,
  input  logic [AW-1:0] rd_addr,
  output logic          we_even,
  output logic          we_odd,
  output logic          fill_sel,
  output logic [31:0]   rd_data
);

  logic [15:0]   mem   [2][2*DEPTH];
  lane_t         sel_l [2];
  logic [AW-1:0] a_w   [2];
  logic [IW-1:0] widx  [2];
  logic          wen   [2];
  logic [15:0]   old   [2];
  logic [15:0]   wdat  [2];
  logic [23:0]   sum24;
  logic [IW-1:0] ridx;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      logic h0, h1;
      h0 = lane0.en && (wide || (lane0.x[0] == b[0]));
      h1 = lane1.en && !wide && (lane1.x[0] == b[0]);
      sel_l[b] = h0 ? lane0 : lane1;
      a_w[b]   = wide ? sel_l[b].x[AW-1:0] : sel_l[b].x[AW:1];
      wen[b]   = h0 || h1;
      widx[b]  = wen[b] ? (IW'(a_w[b]) + (fill_sel ? IW'(DEPTH) : IW'(0))) : '0;
      old[b]   = mem[b][widx[b]];
    end
    sum24 = rmw ? ({old[1][7:0], old[0]} + lane0.col) : lane0.col;
    for (int b = 0; b < 2; b++) begin
      if (wide) wdat[b] = (b == 0) ? sum24[15:0] : {8'h00, sum24[23:16]};
      else      wdat[b] = rmw ? (old[b] + sel_l[b].col[15:0]) : sel_l[b].col[15:0];
    end
  end

  assign we_even = wen[0];
  assign we_odd  = wen[1];
  assign ridx    = IW'(rd_addr) + (fill_sel ? IW'(0) : IW'(DEPTH));

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (wen[b]) mem[b][widx[b]] <= wdat[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_sel <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (swap) fill_sel <= ~fill_sel;
      rd_data <= (32'(rd_addr) < DEPTH) ? {mem[1][ridx], mem[0][ridx]} : 32'd0;
    end
  end

endmodule

// File: rtl/lbw_line_writer.sv
module lbw_line_writer
  import lbw_pkg::*;
#(
  parameter  int DEPTH = 360,
  parameter  int XW    = 11,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          obj_start,
  input  logic [2:0]    cfg_bpp,
  input  logic          cfg_scaled,
  input  logic          cfg_rmw,
  input  logic [XW-1:0] cfg_start_x,
  input  logic          in_valid,
  input  logic [63:0]   in_data,
  output logic          in_ready,
  input  logic          pal_we,
  input  logic [7:0]    pal_idx,
  input  logic [15:0]   pal_color,
  input  logic          swap,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          wr_even,
  output logic          wr_odd
);

  cfg_t        cfg_q;
  logic        fire, pair, wide, fill_sel;
  logic [31:0] px0, px1;
  logic [15:0] x0;
  lane_t       lane0, lane1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{bpp: BPP16, scaled: 1'b0, rmw: 1'b0};
    end else if (obj_start) begin
      cfg_q <= '{bpp: decode_bpp(cfg_bpp), scaled: cfg_scaled, rmw: cfg_rmw};
    end
  end

  assign wide = (cfg_q.bpp == BPP24);

  lbw_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .obj_start(obj_start),
    .start_x(16'(cfg_start_x)), .cfg(cfg_q),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fire(fire), .pair(pair), .px0(px0), .px1(px1), .x0(x0)
  );

  lbw_pixmap #(.DEPTH(DEPTH)) u_pixmap (
    .clk(clk), .pal_we(pal_we), .pal_idx(pal_idx), .pal_color(pal_color),
    .cfg(cfg_q), .fire(fire), .pair(pair), .px0(px0), .px1(px1), .x0(x0),
    .lane0(lane0), .lane1(lane1)
  );

  lbw_linebuf #(.DEPTH(DEPTH)) u_linebuf (
    .clk(clk), .rst_n(rst_n), .swap(swap), .rmw(cfg_q.rmw), .wide(wide),
    .lane0(lane0), .lane1(lane1), .rd_addr(rd_addr),
    .we_even(wr_even), .we_odd(wr_odd), .fill_sel(fill_sel), .rd_data(rd_data)
  );

endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
  parameter int DEPTH = 360
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        swap,
  input logic        fill_sel,
  input logic        we_even,
  input logic        we_odd,
  input logic        rmw,
  input logic        wide,
  input logic        l0_en,
  input logic [15:0] l0_x,
  input logic        l1_en,
  input logic [15:0] l1_x
);

  // R8: an accepted phrase occupies the prefetch slot for the next cycle
  p_prefetch_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6: additive writes never come back to back
  p_rmw_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw && (we_even || we_odd)) |=> !(we_even || we_odd));

  // R9: a swap pulse flips the fill buffer
  p_swap_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (fill_sel != $past(fill_sel)));

  // R9: without a pulse the roles hold
  p_swap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(fill_sel));

  // R7: an enabled lane always lies inside the line
  p_lane_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l0_en |-> (wide ? (32'(l0_x) < DEPTH) : (32'(l0_x) < 2 * DEPTH)));

  // R5: a pixel pair lands in both halves of the buffer
  p_pair_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l0_en && l1_en) |-> ((l0_x[0] != l1_x[0]) && we_even && we_odd));

endmodule

bind lbw_line_writer lbw_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .swap(swap), .fill_sel(fill_sel), .we_even(wr_even), .we_odd(wr_odd),
  .rmw(cfg_q.rmw), .wide(wide),
  .l0_en(lane0.en), .l0_x(lane0.x), .l1_en(lane1.en), .l1_x(lane1.x)
);

// File: tb/sim_lbw_line_writer.sv
module sim_lbw_line_writer;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obj_start = 1'b0;
  logic [2:0]  cfg_bpp = 3'd4;
  logic        cfg_scaled = 1'b0;
  logic        cfg_rmw = 1'b0;
  logic [10:0] cfg_start_x = '0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_idx = '0;
  logic [15:0] pal_color = '0;
  logic        swap = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wr_even, wr_odd;

  lbw_line_writer #(.DEPTH(D), .XW(11)) u0 (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int fsel = 0;
  logic [31:0] expm [2][D];
  logic [15:0] pal_m [256];
  logic [63:0] phr [8];

  // write-strobe monitor
  logic mon_on = 1'b0, prev_w = 1'b0;
  int   cyc = 0, wcnt = 0, first_w = -1, last_w = -1, adj = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (wr_even || wr_odd) begin
        wcnt++;
        if (first_w < 0) first_w = cyc;
        last_w = cyc;
        if (prev_w) adj++;
      end
      prev_w = wr_even || wr_odd;
    end
  end

  int total_cyc = 0;
  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d cycles expected completion", total_cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkph(int seed, int i);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[63-8*k -: 8] = 8'(seed + (i * 8 + k) * 29 + 1);
    return r;
  endfunction

  // reference model for one object
  task automatic model(int bpp, int rmw, int sx, int nph);
    int w, ppp, x, lim;
    logic [63:0] t;
    logic [31:0] raw;
    logic [23:0] col, s24;
    logic [15:0] o16;
    w   = (bpp == 5) ? 32 : (1 << bpp);
    ppp = 64 / w;
    lim = (bpp == 5) ? D : 2 * D;
    for (int i = 0; i < nph; i++) begin
      for (int k = 0; k < ppp; k++) begin
        t   = phr[i] << (k * w);
        raw = 32'(t >> (64 - w));
        x   = sx + i * ppp + k;
        if (x < lim && (bpp == 5 || raw != 0)) begin
          col = (bpp <= 3) ? {8'h00, pal_m[raw[7:0]]} : (bpp == 4) ? {8'h00, raw[15:0]} : raw[23:0];
          if (bpp == 5) begin
            s24 = rmw ? (expm[fsel][x][23:0] + col) : col;
            expm[fsel][x] = {8'h00, s24};
          end else begin
            o16 = x[0] ? expm[fsel][x/2][31:16] : expm[fsel][x/2][15:0];
            o16 = rmw ? 16'(o16 + col[15:0]) : col[15:0];
            if (x[0]) expm[fsel][x/2][31:16] = o16;
            else      expm[fsel][x/2][15:0]  = o16;
          end
        end
      end
    end
  endtask

  logic rdy_after_first;

  task automatic run_obj(int bpp, int sc, int rmw, int sx, int nph);
    @(negedge clk);
    cfg_bpp = 3'(bpp); cfg_scaled = sc[0]; cfg_rmw = rmw[0]; cfg_start_x = 11'(sx);
    obj_start = 1'b1;
    mon_on = 1'b1; cyc = 0; wcnt = 0; first_w = -1; last_w = -1; adj = 0; prev_w = 1'b0;
    @(negedge clk);
    obj_start = 1'b0;
    // R11: scramble settings after the start pulse
    cfg_bpp = ~cfg_bpp; cfg_scaled = ~cfg_scaled; cfg_rmw = ~cfg_rmw; cfg_start_x = ~cfg_start_x;
    for (int i = 0; i < nph; i++) begin
      @(negedge clk);
      if (i == 1) rdy_after_first = in_ready;
      in_valid = 1'b1; in_data = phr[i];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (150) @(negedge clk);
    mon_on = 1'b0;
    model(bpp, rmw, sx, nph);
  endtask

  task automatic do_swap();
    @(negedge clk); swap = 1'b1;
    @(negedge clk); swap = 1'b0;
    fsel = 1 - fsel;
  endtask

  task automatic verify(string req);
    do_swap();
    for (int a = 0; a < D; a++) begin
      @(negedge clk); rd_addr = 3'(a);
      @(negedge clk); chk(req, rd_data, expm[1 - fsel][a]);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int a = 0; a < D; a++) expm[b][a] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 strobes", {30'd0, wr_odd, wr_even}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;

    // R3: load palette
    for (int i = 0; i < 256; i++) begin
      pal_m[i] = 16'(i * 16'h0301 + 16'h0011);
      @(negedge clk); pal_we = 1'b1; pal_idx = 8'(i); pal_color = pal_m[i];
    end
    @(negedge clk); pal_we = 1'b0;

    // clear both buffers with zero 24-bit pixels (R4: zero 24-bit is written)
    for (int i = 0; i < 4; i++) phr[i] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_obj(5, 0, 0, 0, 4); do_swap(); run_obj(5, 0, 0, 0, 4); verify("R4 24-bit fill");
    for (int i = 0; i < 4; i++) phr[i] = '0;
    run_obj(5, 0, 0, 0, 4); verify("R4 24-bit zero written");
    run_obj(5, 0, 0, 0, 4); verify("R4 24-bit zero written");

    // R2 R4 R5 R8: 16-bit unscaled, one transparent pixel
    for (int i = 0; i < 4; i++) phr[i] = mkph(3, i);
    phr[1][47:32] = 16'h0000;
    run_obj(4, 0, 0, 0, 4);
    chk("R8 ready low after accept", 32'(rdy_after_first), 32'd0);
    chk("R5 pair write cycles", 32'(wcnt), 32'd8);
    chk("R5 pair span", 32'(last_w - first_w + 1), 32'd8);
    verify("R2 R4 16-bit unscaled");

    // R5 R7: scaled 16-bit, odd start, tail beyond the line
    for (int i = 0; i < 4; i++) phr[i] = mkph(11, i);
    run_obj(4, 1, 0, 3, 4);
    chk("R5 scaled write cycles", 32'(wcnt), 32'd13);
    chk("R5 scaled span", 32'(last_w - first_w + 1), 32'd13);
    verify("R7 scaled 16-bit");

    // R6: additive 16-bit over existing contents
    for (int i = 0; i < 4; i++) phr[i] = mkph(40, i);
    run_obj(4, 0, 1, 1, 4);
    chk("R6 rmw write cycles", 32'(wcnt), 32'd8);
    chk("R6 rmw no adjacent writes", 32'(adj), 32'd0);
    verify("R6 additive 16-bit");
    for (int i = 0; i < 4; i++) phr[i] = mkph(77, i);
    run_obj(4, 0, 1, 0, 4);
    verify("R6 additive 16-bit second buffer");

    // R2 R3 R4: palette depths at several starts
    for (int i = 0; i < 2; i++) phr[i] = mkph(5, i);
    phr[0][55:48] = 8'h00;
    run_obj(3, 0, 0, 2, 2); verify("R3 8-bit palette");
    phr[0] = mkph(9, 0);   run_obj(2, 0, 0, 5, 1); verify("R3 4-bit palette");
    phr[0] = mkph(21, 0);  run_obj(1, 0, 0, 0, 1); verify("R3 2-bit palette");
    phr[0] = mkph(100, 0); run_obj(0, 0, 0, 1, 1); verify("R3 1-bit palette");
    phr[0] = 64'hA5C3_0F81_7E18_3CC3; run_obj(0, 1, 0, 0, 1); verify("R2 1-bit scaled");

    // R7 R10: 24-bit, odd start
    for (int i = 0; i < 4; i++) phr[i] = mkph(60, i);
    run_obj(5, 0, 0, 1, 4);
    chk("R7 24-bit write cycles", 32'(wcnt), 32'd7);
    chk("R5 24-bit span", 32'(last_w - first_w + 1), 32'd7);
    verify("R10 24-bit entries");

    // R6: additive 24-bit with carries, twice on the same buffer
    for (int i = 0; i < 4; i++) phr[i] = 64'h00FF_FFFF_0000_FFFF + mkph(2, i);
    run_obj(5, 0, 0, 0, 4);
    run_obj(5, 0, 1, 0, 4);
    verify("R6 additive 24-bit");

    // R6: additive scaled palette object
    for (int i = 0; i < 2; i++) phr[i] = mkph(33, i);
    run_obj(3, 1, 1, 0, 2);
    chk("R6 scaled rmw no adjacent writes", 32'(adj), 32'd0);
    verify("R6 additive 8-bit scaled");

    // R9: swap in the middle of reading
    @(negedge clk); rd_addr = 3'd2; swap = 1'b1;
    @(negedge clk); swap = 1'b0;
    chk("R9 read at swap edge sees old display", rd_data, expm[1 - fsel][2]);
    fsel = 1 - fsel;
    @(negedge clk);
    chk("R9 read after swap sees new display", rd_data, expm[1 - fsel][2]);
    @(negedge clk);
    chk("R9 no swap keeps display", rd_data, expm[1 - fsel][2]);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule